// File: doc/BRIEF.md
# Lazy-Conflict Commit Broadcast Unit

This unit sits beside one processor's first-level data cache in a system where every piece of work runs as an optimistic transaction. Loads mark a read bit for the cache line they touch. Stores are held in a small coalescing write buffer until the transaction ends. Nothing is checked against other processors while the transaction runs. When the processor asks to commit, the unit requests the shared commit bus. Once the bus is granted, the unit sends the address and new data of every buffered line, one per cycle. The same bus carries the updates to the lower memory level, and every other unit snoops it.

Every other unit compares each snooped address against its own read bits. On a match it throws its transaction away: it clears the read set, empties the write buffer and pulses `abort`, so that the processor can restore its checkpointed registers and start again.

A transaction that needs one more buffer entry than exists cannot stay speculative. It requests the commit bus and keeps it. It drains what it has already buffered, and from then on it writes straight through to the bus. In this mode it runs alone and cannot be aborted. The bus is released only when that transaction commits.

Top module: `commit_bcast_unit`

## Requirements
- R1: After reset, `abort`, `tx_done`, `bus_req` and `bc_out_valid` are low and `cpu_ready` is high.
- R2: A load accepted in the speculative state sets the read bit of its line. Suppose a broadcast address whose line maps to a set read bit arrives while the unit does not hold the bus. Then `abort` is high for exactly the following cycle. All read bits are cleared, all buffered stores are discarded and the unit returns to the speculative state.
- R3: A broadcast whose line does not map to a set read bit causes no abort. Buffered stores never cause an abort.
- R4: A store to an address already in the buffer replaces that entry's data. A store to a new address takes the next entry. When the buffer drains, each distinct address goes out once, in the order of its first store, carrying its latest data.
- R5: A commit with a non-empty buffer raises `bus_req` in the next cycle and keeps it up until `bus_gnt` is sampled high. The first broadcast appears in the cycle after the grant, with one entry per cycle. In the cycle after the last entry, `bus_req` is low, `tx_done` pulses for one cycle and the read bits are clear.
- R6: A commit with an empty buffer does not touch the bus. `tx_done` pulses in the next cycle and the read bits are cleared.
- R7: `cpu_ready` is low while the unit waits for the bus or drains it, and accesses offered then are not taken. A commit request that comes in the same cycle as `cpu_valid` is ignored.
- R8: A conflict that arrives while the unit waits for the grant aborts the transaction and drops `bus_req`, even when `bus_gnt` is high in that same cycle.
- R9: While the unit holds the bus (draining, or running alone after an overflow), incoming broadcasts never cause an abort.
- R10: A store to a new address while all entries are in use is refused (`cpu_ready` low) and raises `bus_req`. After the grant the buffer drains. From then on each store is accepted and appears on the broadcast outputs in the same cycle. A commit then releases the bus and pulses `tx_done` in the next cycle.
- R11: When an access arrives in the same cycle as a conflicting broadcast, the abort wins. The access leaves no read bit and no buffered store.
- R12: A line's read bit is chosen by XOR-folding the address: address bit b goes into index bit (b mod log2(LINES)). Addresses that fold to the same index conflict with each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_valid | input | 1 | Processor offers a load or store |
| cpu_write | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | ADDR_W | Line address of the access |
| cpu_wdata | input | DATA_W | Store data |
| cpu_commit | input | 1 | End the current transaction (only taken with `cpu_valid` low) |
| cpu_ready | output | 1 | Access is taken this cycle |
| bus_req | output | 1 | Request or hold the shared commit bus |
| bus_gnt | input | 1 | Commit bus granted |
| bc_in_valid | input | 1 | Another unit broadcasts a committed address |
| bc_in_addr | input | ADDR_W | Snooped committed address |
| bc_out_valid | output | 1 | This unit drives a committed line |
| bc_out_addr | output | ADDR_W | Committed line address |
| bc_out_data | output | DATA_W | Committed line data |
| abort | output | 1 | One-cycle pulse: transaction discarded |
| tx_done | output | 1 | One-cycle pulse: committed, next transaction begins |

## Verification
The bench builds the unit with 16 read bits, 8-bit addresses and a four-entry write buffer. With this folding, aliasing pairs such as 0x04 and 0x15 are easy to write. Five stores are enough to reach the overflow path and the non-abortable solo mode. A behavioural model made of queues follows every cycle. Directed sequences then cover several boundary cases: coalescing, aborts on the cycle of a grant, broadcasts ignored while the bus is held, and the read-only commit. A pseudo-random phase then mixes accesses, snoops and grants.

// File: rtl/cbu_pkg.sv
package cbu_pkg;
  typedef enum logic [2:0] {
    ST_SPEC   = 3'd0,
    ST_WAIT   = 3'd1,
    ST_OVWAIT = 3'd2,
    ST_DRAIN  = 3'd3,
    ST_SOLO   = 3'd4
  } cbu_state_e;
endpackage

// File: rtl/cbu_readset.sv
module cbu_readset #(
  parameter int LINES  = 64,
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              set_en,
  input  logic [ADDR_W-1:0] set_addr,
  input  logic              clr,
  input  logic [ADDR_W-1:0] q_addr,
  output logic              q_hit,
  output logic              any
);
  localparam int IDX_W = $clog2(LINES);

  logic [LINES-1:0] bits_q, bits_d;
  logic [IDX_W-1:0] set_idx, q_idx;

  function automatic logic [IDX_W-1:0] fold(input logic [ADDR_W-1:0] a);
    logic [IDX_W-1:0] r;
    r = '0;
    for (int b = 0; b < ADDR_W; b++) r[b % IDX_W] = r[b % IDX_W] ^ a[b];
    return r;
  endfunction

  assign set_idx = fold(set_addr);
  assign q_idx   = fold(q_addr);
  assign q_hit   = bits_q[q_idx];
  assign any     = |bits_q;

  always_comb begin
    bits_d = bits_q;
    if (clr)         bits_d = '0;
    else if (set_en) bits_d[set_idx] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bits_q <= '0;
    else        bits_q <= bits_d;
  end

  // R6: a clear always leaves the read set empty in the next cycle
  assert_clear_empties_R6: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !any);
endmodule

// File: rtl/cbu_wbuf.sv
module cbu_wbuf #(
  parameter int DEPTH  = 4,
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [ADDR_W-1:0]        wr_addr,
  input  logic [DATA_W-1:0]        wr_data,
  input  logic                     clr,
  output logic                     hit,
  output logic                     full,
  output logic [$clog2(DEPTH+1)-1:0] cnt,
  input  logic [((DEPTH>1)?$clog2(DEPTH):1)-1:0] rd_idx,
  output logic [ADDR_W-1:0]        rd_addr,
  output logic [DATA_W-1:0]        rd_data
);
  localparam int CNT_W = $clog2(DEPTH+1);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [ADDR_W-1:0] addr_q [DEPTH];
  logic [ADDR_W-1:0] addr_d [DEPTH];
  logic [DATA_W-1:0] data_q [DEPTH];
  logic [DATA_W-1:0] data_d [DEPTH];
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [DEPTH-1:0]  match;
  logic [PTR_W-1:0]  hit_idx;

  genvar g;
  generate
    for (g = 0; g < DEPTH; g++) begin : g_cmp
      assign match[g] = (CNT_W'(g) < cnt_q) && (addr_q[g] == wr_addr);
    end
  endgenerate

  always_comb begin
    hit_idx = '0;
    for (int i = DEPTH - 1; i >= 0; i--) if (match[i]) hit_idx = PTR_W'(i);
  end

  assign hit     = |match;
  assign full    = (cnt_q == CNT_W'(DEPTH));
  assign cnt     = cnt_q;
  assign rd_addr = addr_q[rd_idx];
  assign rd_data = data_q[rd_idx];

  always_comb begin
    cnt_d  = cnt_q;
    addr_d = addr_q;
    data_d = data_q;
    if (clr) begin
      cnt_d = '0;
    end else if (wr_en) begin
      if (hit) begin
        data_d[hit_idx] = wr_data;
      end else if (!full) begin
        addr_d[cnt_q[PTR_W-1:0]] = wr_addr;
        data_d[cnt_q[PTR_W-1:0]] = wr_data;
        cnt_d = cnt_q + CNT_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      for (int i = 0; i < DEPTH; i++) begin
        addr_q[i] <= '0;
        data_q[i] <= '0;
      end
    end else begin
      cnt_q  <= cnt_d;
      addr_q <= addr_d;
      data_q <= data_d;
    end
  end

  assert_fill_bound_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(DEPTH));
  // R10: the controller never hands over a store that has no entry
  assert_no_lost_store_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !clr) |-> (hit || !full));
endmodule

// File: rtl/cbu_ctrl.sv
module cbu_ctrl
  import cbu_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cpu_valid,
  input  logic                     cpu_write,
  input  logic                     cpu_commit,
  input  logic                     snoop_hit,
  input  logic                     wb_hit,
  input  logic                     wb_full,
  input  logic [$clog2(DEPTH+1)-1:0] wb_cnt,
  input  logic                     bus_gnt,
  output logic                     cpu_ready,
  output logic                     bus_req,
  output logic                     rs_set,
  output logic                     rs_clr,
  output logic                     wb_wr,
  output logic                     wb_clr,
  output logic [((DEPTH>1)?$clog2(DEPTH):1)-1:0] rd_idx,
  output logic                     out_valid,
  output logic                     out_from_buf,
  output logic                     abort,
  output logic                     tx_done
);
  localparam int CNT_W = $clog2(DEPTH+1);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  cbu_state_e       st_q, st_d;
  logic [CNT_W-1:0] ptr_q, ptr_d;
  logic             solo_q, solo_d;
  logic             abort_q, abort_d, done_q, done_d;
  logic             ovf, cmt, exposed, conflict, acc, last;

  assign ovf      = cpu_valid && cpu_write && !wb_hit && wb_full;
  assign cmt      = cpu_commit && !cpu_valid;
  assign exposed  = (st_q == ST_SPEC) || (st_q == ST_WAIT) || (st_q == ST_OVWAIT);
  assign conflict = snoop_hit && exposed;
  assign cpu_ready = ((st_q == ST_SPEC) && !ovf) || (st_q == ST_SOLO);
  assign acc      = cpu_valid && cpu_ready && !conflict;
  assign rs_set   = acc && !cpu_write;
  assign wb_wr    = acc && cpu_write && (st_q == ST_SPEC);
  assign last     = (ptr_q + CNT_W'(1)) == wb_cnt;
  assign rd_idx   = ptr_q[PTR_W-1:0];
  assign out_from_buf = (st_q == ST_DRAIN);
  assign out_valid = out_from_buf || ((st_q == ST_SOLO) && cpu_valid && cpu_write);
  assign bus_req  = (st_q != ST_SPEC);
  assign abort    = abort_q;
  assign tx_done  = done_q;

  always_comb begin
    st_d    = st_q;
    ptr_d   = ptr_q;
    solo_d  = solo_q;
    abort_d = 1'b0;
    done_d  = 1'b0;
    rs_clr  = 1'b0;
    wb_clr  = 1'b0;
    unique case (st_q)
      ST_SPEC: begin
        if (conflict) begin
          abort_d = 1'b1; rs_clr = 1'b1; wb_clr = 1'b1;
        end else if (ovf) begin
          st_d = ST_OVWAIT;
        end else if (cmt) begin
          if (wb_cnt == '0) begin
            done_d = 1'b1; rs_clr = 1'b1;
          end else begin
            st_d = ST_WAIT;
          end
        end
      end
      ST_WAIT, ST_OVWAIT: begin
        if (conflict) begin
          st_d = ST_SPEC; abort_d = 1'b1; rs_clr = 1'b1; wb_clr = 1'b1;
        end else if (bus_gnt) begin
          st_d   = ST_DRAIN;
          ptr_d  = '0;
          solo_d = (st_q == ST_OVWAIT);
        end
      end
      ST_DRAIN: begin
        if (last) begin
          wb_clr = 1'b1;
          if (solo_q) begin
            st_d = ST_SOLO;
          end else begin
            st_d = ST_SPEC; done_d = 1'b1; rs_clr = 1'b1;
          end
        end else begin
          ptr_d = ptr_q + CNT_W'(1);
        end
      end
      ST_SOLO: begin
        if (cmt) begin
          st_d = ST_SPEC; done_d = 1'b1; rs_clr = 1'b1;
        end
      end
      default: st_d = ST_SPEC;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_SPEC;
      ptr_q   <= '0;
      solo_q  <= 1'b0;
      abort_q <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      st_q    <= st_d;
      ptr_q   <= ptr_d;
      solo_q  <= solo_d;
      abort_q <= abort_d;
      done_q  <= done_d;
    end
  end

  assert_abort_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    abort_q |=> !abort_q);
  assert_held_no_abort_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ((st_q == ST_DRAIN) || (st_q == ST_SOLO)) |=> !abort_q);
  assert_done_vs_abort_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(abort_q && done_q));
  assert_release_after_done_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> !bus_req);
endmodule

// File: rtl/commit_bcast_unit.sv
module commit_bcast_unit #(
  parameter int ADDR_W   = 12,
  parameter int DATA_W   = 32,
  parameter int LINES    = 64,
  parameter int WB_DEPTH = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_valid,
  input  logic              cpu_write,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  input  logic              cpu_commit,
  output logic              cpu_ready,
  output logic              bus_req,
  input  logic              bus_gnt,
  input  logic              bc_in_valid,
  input  logic [ADDR_W-1:0] bc_in_addr,
  output logic              bc_out_valid,
  output logic [ADDR_W-1:0] bc_out_addr,
  output logic [DATA_W-1:0] bc_out_data,
  output logic              abort,
  output logic              tx_done
);
  localparam int CNT_W = $clog2(WB_DEPTH+1);
  localparam int PTR_W = (WB_DEPTH > 1) ? $clog2(WB_DEPTH) : 1;

  logic              rs_set, rs_clr, rs_hit, rs_any;
  logic              wb_wr, wb_clr, wb_hit, wb_full;
  logic [CNT_W-1:0]  wb_cnt;
  logic [PTR_W-1:0]  rd_idx;
  logic [ADDR_W-1:0] rd_addr;
  logic [DATA_W-1:0] rd_data;
  logic              from_buf;

  cbu_readset #(.LINES(LINES), .ADDR_W(ADDR_W)) u_rs (
    .clk(clk), .rst_n(rst_n), .set_en(rs_set), .set_addr(cpu_addr),
    .clr(rs_clr), .q_addr(bc_in_addr), .q_hit(rs_hit), .any(rs_any)
  );

  cbu_wbuf #(.DEPTH(WB_DEPTH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_wb (
    .clk(clk), .rst_n(rst_n), .wr_en(wb_wr), .wr_addr(cpu_addr),
    .wr_data(cpu_wdata), .clr(wb_clr), .hit(wb_hit), .full(wb_full),
    .cnt(wb_cnt), .rd_idx(rd_idx), .rd_addr(rd_addr), .rd_data(rd_data)
  );

  cbu_ctrl #(.DEPTH(WB_DEPTH)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .cpu_valid(cpu_valid), .cpu_write(cpu_write),
    .cpu_commit(cpu_commit), .snoop_hit(bc_in_valid && rs_hit),
    .wb_hit(wb_hit), .wb_full(wb_full), .wb_cnt(wb_cnt), .bus_gnt(bus_gnt),
    .cpu_ready(cpu_ready), .bus_req(bus_req), .rs_set(rs_set), .rs_clr(rs_clr),
    .wb_wr(wb_wr), .wb_clr(wb_clr), .rd_idx(rd_idx), .out_valid(bc_out_valid),
    .out_from_buf(from_buf), .abort(abort), .tx_done(tx_done)
  );

  assign bc_out_addr = from_buf ? rd_addr : cpu_addr;
  assign bc_out_data = from_buf ? rd_data : cpu_wdata;

  // R2: an abort leaves no read bit behind
  assert_abort_clean_R2: assert property (@(posedge clk) disable iff (!rst_n)
    abort |-> !rs_any);
  // R6: a finished transaction starts the next one with an empty read set
  assert_done_clean_R6: assert property (@(posedge clk) disable iff (!rst_n)
    tx_done |-> !rs_any);
endmodule

// File: tb/commit_bcast_unit_tb_top.sv
module commit_bcast_unit_tb_top;
  localparam int AW = 8, DW = 16, LN = 16, WB = 4, IW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic v = 0, w = 0, c = 0, bv = 0, gnt = 0;
  logic [AW-1:0] a = '0, ba = '0;
  logic [DW-1:0] d = '0;
  logic rdy, req, ov, ab, dn;
  logic [AW-1:0] oa;
  logic [DW-1:0] od;

  always #2 clk = ~clk;

  commit_bcast_unit #(.ADDR_W(AW), .DATA_W(DW), .LINES(LN), .WB_DEPTH(WB)) dut_i (
    .clk(clk), .rst_n(rst_n), .cpu_valid(v), .cpu_write(w), .cpu_addr(a),
    .cpu_wdata(d), .cpu_commit(c), .cpu_ready(rdy), .bus_req(req), .bus_gnt(gnt),
    .bc_in_valid(bv), .bc_in_addr(ba), .bc_out_valid(ov), .bc_out_addr(oa),
    .bc_out_data(od), .abort(ab), .tx_done(dn)
  );

  // behavioural reference: 0 spec, 1 wait, 2 overflow wait, 3 drain, 4 solo
  int m_st, m_ptr;
  bit m_solo, m_ab, m_dn;
  bit [LN-1:0] m_rs;
  logic [AW-1:0] qa[$];
  logic [DW-1:0] qd[$];
  int vectors = 0, miss = 0, cycles = 0;
  string cur_req = "R1";

  function automatic int fold(input logic [AW-1:0] x);
    int r = 0;
    for (int b = 0; b < AW; b++) if (x[b]) r = r ^ (1 << (b % IW));
    return r;
  endfunction

  function automatic int find(input logic [AW-1:0] x);
    for (int i = 0; i < qa.size(); i++) if (qa[i] == x) return i;
    return -1;
  endfunction

  function automatic bit m_ovf();
    return v && w && find(a) < 0 && qa.size() == WB;
  endfunction

  function automatic bit m_rdy();
    return (m_st == 0 && !m_ovf()) || m_st == 4;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st = 0; m_ptr = 0; m_solo = 0; m_ab = 0; m_dn = 0; m_rs = '0;
      qa.delete(); qd.delete();
    end else begin
      bit conf, acc, cmt, na, nd;
      int k;
      na = 0; nd = 0;
      cmt = c && !v;
      conf = bv && m_rs[fold(ba)] && (m_st <= 2);
      acc = v && m_rdy() && !conf;
      if (acc && !w) m_rs[fold(a)] = 1'b1;
      if (acc && w && m_st == 0) begin
        k = find(a);
        if (k >= 0) qd[k] = d; else begin qa.push_back(a); qd.push_back(d); end
      end
      case (m_st)
        0: if (conf) begin na = 1; m_rs = '0; qa.delete(); qd.delete(); end
           else if (m_ovf()) m_st = 2;
           else if (cmt) begin
             if (qa.size() == 0) begin nd = 1; m_rs = '0; end else m_st = 1;
           end
        1, 2: if (conf) begin m_st = 0; na = 1; m_rs = '0; qa.delete(); qd.delete(); end
              else if (gnt) begin m_solo = (m_st == 2); m_st = 3; m_ptr = 0; end
        3: if (m_ptr == qa.size() - 1) begin
             qa.delete(); qd.delete();
             if (m_solo) m_st = 4; else begin m_st = 0; nd = 1; m_rs = '0; end
           end else m_ptr++;
        4: if (cmt) begin m_st = 0; nd = 1; m_rs = '0; end
        default: ;
      endcase
      m_ab = na; m_dn = nd;
    end
  end

  task automatic cmp1(input string nm, input int act, input int exp);
    if (act != exp) begin
      miss++;
      $display("FAIL %s %s actual=%0h expected=%0h at cycle %0d", cur_req, nm, act, exp, cycles);
    end
  endtask

  task automatic check();
    bit e_ov;
    vectors++;
    e_ov = (m_st == 3) || (m_st == 4 && v && w);
    cmp1("cpu_ready", rdy, m_rdy());
    cmp1("bus_req", req, m_st != 0);
    cmp1("bc_out_valid", ov, e_ov);
    cmp1("abort", ab, m_ab);
    cmp1("tx_done", dn, m_dn);
    if (e_ov && m_st == 3) begin
      cmp1("bc_out_addr", oa, qa[m_ptr]);
      cmp1("bc_out_data", od, qd[m_ptr]);
    end else if (e_ov) begin
      cmp1("bc_out_addr", oa, a);
      cmp1("bc_out_data", od, d);
    end
  endtask

  task automatic cyc(input bit iv, iw, input logic [AW-1:0] ia, input logic [DW-1:0] id,
                     input bit ic, ibv, input logic [AW-1:0] iba);
    @(negedge clk);
    v = iv; w = iw; a = ia; d = id; c = ic; bv = ibv; ba = iba;
    #1 check();
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(0, 0, 0, 0, 0, 0, 0);
  endtask
  task automatic ld(input logic [AW-1:0] x); cyc(1, 0, x, 0, 0, 0, 0); endtask
  task automatic st(input logic [AW-1:0] x, input logic [DW-1:0] y); cyc(1, 1, x, y, 0, 0, 0); endtask
  task automatic cm(); cyc(0, 0, 0, 0, 1, 0, 0); endtask
  task automatic snoop(input logic [AW-1:0] x); cyc(0, 0, 0, 0, 0, 1, x); endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miss);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      miss++;
      $display("FAIL watchdog actual=%0d expected<=20000", cycles);
      finish_run();
    end
  end

  initial begin
    bit [15:0] lf;
    cur_req = "R1";
    for (int i = 0; i < 3; i++) begin @(negedge clk); #1 check(); end
    @(negedge clk); rst_n = 1'b1;
    idle(2);
    // R3 R4 R5 R7: coalescing, harmless snoop, delayed grant, stalled accesses
    cur_req = "R4"; ld(8'h03); st(8'h10, 16'h1111); st(8'h20, 16'h2222); st(8'h10, 16'h3333);
    cur_req = "R3"; snoop(8'h05); snoop(8'h10);
    cur_req = "R7"; cm(); ld(8'h03); cyc(1, 1, 8'h33, 16'h9, 1, 0, 0); idle(1);
    cur_req = "R5"; gnt = 1; idle(4); gnt = 0; idle(1);
    // R6: read-only commit
    cur_req = "R6"; ld(8'h07); cm(); idle(1); snoop(8'h07);
    // R2 and R12: aliasing snoop aborts, buffer gone
    cur_req = "R12"; ld(8'h04); st(8'h30, 16'hAAAA); snoop(8'h15);
    cur_req = "R2"; idle(1); cm(); snoop(8'h04); idle(1);
    // R11: abort wins over a store in the same cycle
    cur_req = "R11"; ld(8'h02); cyc(1, 1, 8'h40, 16'h4040, 0, 1, 8'h02); cm(); idle(1);
    // R8: conflict arrives with the grant
    cur_req = "R8"; ld(8'h0A); st(8'h11, 16'h1212); cm(); idle(1);
    gnt = 1; snoop(8'h0A); gnt = 0; idle(2);
    // R10 R9: overflow, solo mode, snoops ignored while holding the bus
    cur_req = "R10"; ld(8'h01);
    for (int i = 0; i < 4; i++) st(AW'(8'h50 + i), DW'(16'h500 + i));
    st(8'h54, 16'h0BAD);
    gnt = 1; st(8'h54, 16'h0BAD);
    cur_req = "R9"; cyc(1, 1, 8'h54, 16'h0BAD, 0, 1, 8'h01); cyc(1, 1, 8'h54, 16'h0BAD, 0, 1, 8'h01);
    st(8'h54, 16'h0BAD); st(8'h54, 16'h0BAD); st(8'h54, 16'h0BAD);
    cur_req = "R10"; st(8'h55, 16'h5555); snoop(8'h01); ld(8'h01); cm(); gnt = 0; idle(2);
    // mixed pseudo-random traffic
    cur_req = "R5"; lf = 16'hACE1;
    for (int i = 0; i < 600; i++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      gnt = lf[0];
      cyc(lf[1] & lf[2], lf[3], {2'b00, lf[9:4]}, lf, lf[10] & ~lf[11], lf[12] & lf[13], {2'b00, lf[15:10]});
    end
    gnt = 0; idle(2);
    finish_run();
  end
endmodule